// File: doc/BRIEF.md
# Verified Scratchpad Write Controller

This block is the scratchpad front end of a small authenticated memory device. It takes bytes that have already been deserialized from the host link and decodes two commands. A write command is followed by a two-byte target address and eight data bytes. The block aligns the target address to an 8-byte boundary, stores the data and, if the host clocks further, returns an inverted CRC-16. A read command replays the stored target address, a status byte and the eight stored bytes, then an inverted CRC-16 that lets the host confirm the transfer.

The status byte holds two live flags. The partial flag marks scratchpad contents that cannot be trusted: after power-up, after a write that ended early, or after a write whose last byte was cut short. The copy-accepted flag is set by a strobe from the memory-side copy engine and is cleared by the next write command. Transactions are framed by an end-of-transaction pulse that also reports how many bits of a trailing partial byte were seen.

Top module: `spad_front`

## Requirements
- R1: After reset the block waits for a command: `in_ready` is 1 and `out_valid` is 0. The partial flag reads 1, the copy-accepted flag reads 0, and the stored address and all eight data bytes read 0.
- R2: Write command 0x0F is followed by TA1 (address low byte), TA2 (high byte) and eight data bytes. The stored address has TA1 bits [2:0] forced to 0. Data byte k is stored in scratchpad slot k.
- R3: Once the eighth data byte has been taken, the block offers two output bytes. They are the bitwise inverse of a CRC-16 with polynomial x^16+x^15+x^2+1, initial value 0, data shifted in LSB first, low byte first. The CRC covers the command byte, TA1 and TA2 as sent (before alignment) and the eight data bytes.
- R4: Read command 0xAA returns, in order: stored TA1, stored TA2, the status byte, data slots 0 to 7, and then the inverted CRC (same algorithm, low byte first) over the command byte and those eleven bytes.
- R5: Status byte layout: bit 7 is the copy-accepted flag and bit 5 is the partial flag. Bits 6, 4, 3 and 2..0 always read 1.
- R6: Accepting a write command sets the partial flag. Taking the eighth data byte clears it. An end-of-transaction pulse with a nonzero residual-bit count during a write transaction sets it again. A nonzero count during any other transaction leaves it unchanged.
- R7: A `copy_done` strobe sets the copy-accepted flag. Accepting a write command clears it, and the clear wins when both fall in the same cycle.
- R8: Any other command byte is discarded: `in_ready` stays 1, `out_valid` stays 0, and no flag, address or data changes until the end-of-transaction pulse.
- R9: An end-of-transaction pulse aborts any transaction in progress. The next accepted byte is treated as a command.
- R10: `in_ready` and `out_valid` are never 1 together. While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| in_valid | input | 1 | Host byte available |
| in_data | input | 8 | Host byte |
| in_ready | output | 1 | Block accepts a host byte this cycle |
| out_valid | output | 1 | Response byte available |
| out_data | output | 8 | Response byte |
| out_ready | input | 1 | Host takes the response byte this cycle |
| txn_end | input | 1 | End-of-transaction pulse; the next byte is a command |
| txn_resid | input | 3 | Bits of the trailing partial byte, valid with `txn_end` |
| copy_done | input | 1 | Memory side finished copying the scratchpad |

## Verification
The assertions assume that `txn_end` is a single-cycle pulse, and that a byte offered in the same cycle as `txn_end` is dropped rather than taken. They also assume `copy_done` never arrives while a status byte is waiting to be taken, because that strobe legitimately changes the held byte. The stimulus never raises `in_valid` or `out_ready` in a cycle that carries `txn_end`. It pulses `copy_done` only between transactions or together with a write command byte. Every handshake is driven one full cycle at a time.

// File: rtl/spad_pkg.sv
package spad_pkg;

    localparam logic [7:0]  CMD_WRITE    = 8'h0F;
    localparam logic [7:0]  CMD_READ     = 8'hAA;
    localparam logic [15:0] CRC_POLY_REF = 16'hA001;  // x^16+x^15+x^2+1, reflected

    typedef enum logic [2:0] {
        ST_CMD,
        ST_ADDR,
        ST_DATA,
        ST_WCRC,
        ST_RDOUT,
        ST_HALT
    } spad_st_e;

    typedef struct packed {
        logic aa;   // copy accepted
        logic pf;   // partial / invalid contents
    } spad_flags_t;

    // One byte through the CRC, least significant bit first
    function automatic logic [15:0] crc16_upd(input logic [15:0] crc_in, input logic [7:0] d);
        logic [15:0] c;
        logic        fb;
        c = crc_in;
        for (int i = 0; i < 8; i++) begin
            fb = c[0] ^ d[i];
            c  = c >> 1;
            if (fb) c = c ^ CRC_POLY_REF;
        end
        return c;
    endfunction

    // Status byte: unused positions and ending offset read as ones
    function automatic logic [7:0] status_pack(input spad_flags_t f);
        return {f.aa, 1'b1, f.pf, 5'b11111};
    endfunction

endpackage

// File: rtl/spad_crc.sv
module spad_crc (
    input  logic        clk,
    input  logic        rst,
    input  logic        seed,
    input  logic        upd,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    import spad_pkg::*;

    always_ff @(posedge clk) begin
        if (rst)       crc <= '0;
        else if (seed) crc <= crc16_upd(16'h0000, din);
        else if (upd)  crc <= crc16_upd(crc, din);
    end
endmodule

// File: rtl/spad_store.sv
module spad_store #(
    parameter int NBYTES = 8,
    localparam int IDXW  = $clog2(NBYTES)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ta_lo_we,
    input  logic            ta_hi_we,
    input  logic            d_we,
    input  logic [IDXW-1:0] d_idx,
    input  logic [7:0]      din,
    input  logic [IDXW-1:0] rd_idx,
    output logic [15:0]     ta,
    output logic [7:0]      rd_byte
);
    logic [7:0] slot [NBYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            ta <= '0;
        end else begin
            if (ta_lo_we) ta[7:0]  <= {din[7:3], 3'b000};
            if (ta_hi_we) ta[15:8] <= din;
        end
    end

    for (genvar g = 0; g < NBYTES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)                                   slot[g] <= '0;
            else if (d_we && d_idx == IDXW'(g))        slot[g] <= din;
        end
    end

    assign rd_byte = slot[rd_idx];
endmodule

// File: rtl/spad_flags.sv
module spad_flags (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_begin,
    input  logic                  wr_full,
    input  logic                  partial_end,
    input  logic                  copy_done,
    output spad_pkg::spad_flags_t flags
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags.pf <= 1'b1;
            flags.aa <= 1'b0;
        end else begin
            if (wr_begin || partial_end) flags.pf <= 1'b1;
            else if (wr_full)            flags.pf <= 1'b0;

            if (wr_begin)       flags.aa <= 1'b0;
            else if (copy_done) flags.aa <= 1'b1;
        end
    end
endmodule

// File: rtl/spad_front.sv
module spad_front #(
    parameter int NBYTES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    output logic       out_valid,
    output logic [7:0] out_data,
    input  logic       out_ready,
    input  logic       txn_end,
    input  logic [2:0] txn_resid,
    input  logic       copy_done
);
    import spad_pkg::*;

    localparam int IDXW    = $clog2(NBYTES);
    localparam int RD_BODY = NBYTES + 3;
    localparam int CW      = $clog2(RD_BODY + 3);
    localparam logic [CW-1:0] LAST_DATA = CW'(NBYTES - 1);
    localparam logic [CW-1:0] RD_CRC_LO = CW'(RD_BODY);
    localparam logic [CW-1:0] RD_CRC_HI = CW'(RD_BODY + 1);

    spad_st_e      st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          in_write_q;
    spad_flags_t   flags;
    logic [15:0]   crc;
    logic [15:0]   ta;
    logic [7:0]    slot_byte;
    logic [IDXW-1:0] rd_idx;

    logic in_fire, out_fire;
    logic crc_seed, crc_upd;
    logic [7:0] crc_din;
    logic ta_lo_we, ta_hi_we, d_we;
    logic wr_begin, wr_full, partial_end;

    assign in_ready  = (st_q == ST_CMD) || (st_q == ST_ADDR) ||
                       (st_q == ST_DATA) || (st_q == ST_HALT);
    assign out_valid = (st_q == ST_WCRC) || (st_q == ST_RDOUT);
    assign in_fire   = in_valid  && in_ready  && !txn_end;
    assign out_fire  = out_valid && out_ready && !txn_end;

    assign rd_idx = IDXW'(cnt_q - CW'(3));

    // Response byte selection
    always_comb begin
        out_data = 8'h00;
        if (st_q == ST_WCRC) begin
            out_data = (cnt_q == '0) ? ~crc[7:0] : ~crc[15:8];
        end else if (st_q == ST_RDOUT) begin
            if (cnt_q == CW'(0))          out_data = ta[7:0];
            else if (cnt_q == CW'(1))     out_data = ta[15:8];
            else if (cnt_q == CW'(2))     out_data = status_pack(flags);
            else if (cnt_q < RD_CRC_LO)   out_data = slot_byte;
            else if (cnt_q == RD_CRC_LO)  out_data = ~crc[7:0];
            else                          out_data = ~crc[15:8];
        end
    end

    // Sequencer
    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        crc_seed = 1'b0;
        crc_upd  = 1'b0;
        crc_din  = in_data;
        ta_lo_we = 1'b0;
        ta_hi_we = 1'b0;
        d_we     = 1'b0;
        wr_begin = 1'b0;
        wr_full  = 1'b0;
        unique case (st_q)
            ST_CMD: if (in_fire) begin
                crc_seed = 1'b1;
                cnt_d    = '0;
                if (in_data == CMD_WRITE) begin
                    st_d     = ST_ADDR;
                    wr_begin = 1'b1;
                end else if (in_data == CMD_READ) begin
                    st_d = ST_RDOUT;
                end else begin
                    st_d = ST_HALT;
                end
            end
            ST_ADDR: if (in_fire) begin
                crc_upd = 1'b1;
                if (cnt_q == '0) begin
                    ta_lo_we = 1'b1;
                    cnt_d    = CW'(1);
                end else begin
                    ta_hi_we = 1'b1;
                    cnt_d    = '0;
                    st_d     = ST_DATA;
                end
            end
            ST_DATA: if (in_fire) begin
                crc_upd = 1'b1;
                d_we    = 1'b1;
                cnt_d   = cnt_q + CW'(1);
                if (cnt_q == LAST_DATA) begin
                    wr_full = 1'b1;
                    cnt_d   = '0;
                    st_d    = ST_WCRC;
                end
            end
            ST_WCRC: if (out_fire) begin
                cnt_d = cnt_q + CW'(1);
                if (cnt_q != '0) st_d = ST_HALT;
            end
            ST_RDOUT: if (out_fire) begin
                crc_din = out_data;
                crc_upd = (cnt_q < RD_CRC_LO);
                cnt_d   = cnt_q + CW'(1);
                if (cnt_q == RD_CRC_HI) st_d = ST_HALT;
            end
            ST_HALT: ;
            default: st_d = ST_HALT;
        endcase
        if (txn_end) begin
            st_d  = ST_CMD;
            cnt_d = '0;
        end
    end

    assign partial_end = txn_end && in_write_q && (txn_resid != 3'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_CMD;
            cnt_q      <= '0;
            in_write_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (txn_end)       in_write_q <= 1'b0;
            else if (wr_begin) in_write_q <= 1'b1;
        end
    end

    spad_crc i_crc (
        .clk  (clk),
        .rst  (rst),
        .seed (crc_seed),
        .upd  (crc_upd),
        .din  (crc_din),
        .crc  (crc)
    );

    spad_store #(.NBYTES(NBYTES)) i_store (
        .clk      (clk),
        .rst      (rst),
        .ta_lo_we (ta_lo_we),
        .ta_hi_we (ta_hi_we),
        .d_we     (d_we),
        .d_idx    (cnt_q[IDXW-1:0]),
        .din      (in_data),
        .rd_idx   (rd_idx),
        .ta       (ta),
        .rd_byte  (slot_byte)
    );

    spad_flags i_flags (
        .clk         (clk),
        .rst         (rst),
        .wr_begin    (wr_begin),
        .wr_full     (wr_full),
        .partial_end (partial_end),
        .copy_done   (copy_done),
        .flags       (flags)
    );
endmodule

// File: rtl/spad_chk.sv
module spad_chk (
    input logic                  clk,
    input logic                  rst,
    input logic                  in_valid,
    input logic [7:0]            in_data,
    input logic                  in_ready,
    input logic                  out_valid,
    input logic [7:0]            out_data,
    input logic                  out_ready,
    input logic                  txn_end,
    input logic [2:0]            txn_resid,
    input logic                  copy_done,
    input spad_pkg::spad_st_e    st,
    input logic                  in_write,
    input spad_pkg::spad_flags_t flags
);
    import spad_pkg::*;

    logic seen = 1'b0;
    always_ff @(posedge clk) seen <= 1'b1;

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        (seen && $past(rst)) |-> (in_ready && !out_valid && flags.pf && !flags.aa)); // R1

    AST_NO_BOTH_DIR: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid)); // R10

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !txn_end && !copy_done) |=> (out_valid && $stable(out_data))); // R10

    AST_WR_CMD_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CMD && in_valid && in_ready && !txn_end && in_data == CMD_WRITE)
        |=> (flags.pf && !flags.aa)); // R7

    AST_COPY_SETS: assert property (@(posedge clk) disable iff (rst)
        (copy_done && !(st == ST_CMD && in_valid && !txn_end && in_data == CMD_WRITE))
        |=> flags.aa); // R7

    AST_PARTIAL_END: assert property (@(posedge clk) disable iff (rst)
        (txn_end && in_write && txn_resid != 3'd0) |=> flags.pf); // R6

    AST_END_TO_CMD: assert property (@(posedge clk) disable iff (rst)
        txn_end |=> (st == ST_CMD && in_ready && !out_valid)); // R9

    AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HALT) |-> (in_ready && !out_valid)); // R8
endmodule

bind spad_front spad_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready),
    .txn_end   (txn_end),
    .txn_resid (txn_resid),
    .copy_done (copy_done),
    .st        (st_q),
    .in_write  (in_write_q),
    .flags     (flags)
);

// File: tb/test_spad_front.sv
module test_spad_front;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_ready = 1'b0;
    logic       txn_end = 1'b0;
    logic [2:0] txn_resid = 3'd0;
    logic       copy_done = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;

    // Bench-side model of the scratchpad
    logic [7:0] m_ta1, m_ta2;
    logic [7:0] m_data [8];
    logic       m_pf, m_aa;
    logic [7:0] wbuf [8];

    always #10 clk = ~clk;  // 50 MHz

    spad_front i_spad_front (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_ready (out_ready),
        .txn_end   (txn_end),
        .txn_resid (txn_resid),
        .copy_done (copy_done)
    );

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        logic        x;
        r = c;
        for (int i = 0; i < 8; i++) begin
            x = r[0] ^ b[i];
            r = {1'b0, r[15:1]};
            if (x) r = r ^ 16'hA001;
        end
        return r;
    endfunction

    function automatic logic [7:0] exp_status();
        return {m_aa, 1'b1, m_pf, 1'b1, 1'b1, 3'b111};
    endfunction

    task automatic check8(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic recv_byte(output logic [7:0] b);
        @(negedge clk);
        out_ready = 1'b1;
        while (!out_valid) @(negedge clk);
        b = out_data;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic end_txn(input logic [2:0] resid);
        @(negedge clk);
        txn_end   = 1'b1;
        txn_resid = resid;
        @(negedge clk);
        txn_end   = 1'b0;
        txn_resid = 3'd0;
    endtask

    task automatic pulse_copy();
        @(negedge clk);
        copy_done = 1'b1;
        @(negedge clk);
        copy_done = 1'b0;
        m_aa = 1'b1;
    endtask

    // Write transaction: nb data bytes from wbuf, optional CRC readback
    task automatic do_write(input logic [7:0] ta1, input logic [7:0] ta2, input int nb,
                            input bit take_crc, input logic [2:0] resid, input bit copy_at_cmd);
        logic [15:0] c;
        logic [7:0]  lo, hi;
        c = ref_crc(16'h0000, 8'h0F);
        @(negedge clk);
        in_valid  = 1'b1;
        in_data   = 8'h0F;
        copy_done = copy_at_cmd;
        @(negedge clk);
        in_valid  = 1'b0;
        copy_done = 1'b0;
        m_aa = 1'b0;
        m_pf = 1'b1;
        send_byte(ta1); c = ref_crc(c, ta1);
        send_byte(ta2); c = ref_crc(c, ta2);
        m_ta1 = {ta1[7:3], 3'b000};
        m_ta2 = ta2;
        for (int i = 0; i < nb; i++) begin
            send_byte(wbuf[i]);
            c = ref_crc(c, wbuf[i]);
            m_data[i] = wbuf[i];
        end
        if (nb == 8) m_pf = 1'b0;
        if (take_crc) begin
            recv_byte(lo);
            recv_byte(hi);
            check8("R3", "write crc low", lo, ~c[7:0]);
            check8("R3", "write crc high", hi, ~c[15:8]);
        end
        end_txn(resid);
        if (resid != 3'd0) m_pf = 1'b1;
    endtask

    // Full read with an output stall on one byte
    task automatic read_check(input string st_req);
        logic [15:0] c;
        logic [7:0]  e [11];
        logic [7:0]  got, held;
        e[0] = m_ta1;
        e[1] = m_ta2;
        e[2] = exp_status();
        for (int i = 0; i < 8; i++) e[3+i] = m_data[i];
        c = ref_crc(16'h0000, 8'hAA);
        send_byte(8'hAA);
        for (int k = 0; k < 11; k++) begin
            if (k == 5) begin
                @(negedge clk);
                held = out_data;
                repeat (3) @(negedge clk);
                n_cmp++;
                if (!(out_valid && out_data == held)) begin
                    n_bad++;
                    $display("FAIL R10 stalled output: actual %0b/%02h expected 1/%02h",
                             out_valid, out_data, held);
                end
            end
            recv_byte(got);
            if (k < 2)       check8("R2", "stored address", got, e[k]);
            else if (k == 2) check8(st_req, "status byte", got, e[k]);
            else             check8("R2", "stored data", got, e[k]);
            c = ref_crc(c, e[k]);
        end
        recv_byte(got);
        check8("R4", "read crc low", got, ~c[7:0]);
        recv_byte(got);
        check8("R4", "read crc high", got, ~c[15:8]);
        end_txn(3'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        n_cmp++;
        if (!(in_ready && !out_valid)) begin
            n_bad++;
            $display("FAIL R1 idle after reset: actual ready=%0b valid=%0b expected 1/0", in_ready, out_valid);
        end
        m_ta1 = 8'h00; m_ta2 = 8'h00; m_pf = 1'b1; m_aa = 1'b0;
        for (int i = 0; i < 8; i++) m_data[i] = 8'h00;
        read_check("R1");
    endtask

    task automatic t_full_write();
        for (int i = 0; i < 8; i++) wbuf[i] = 8'h11 * (i + 1);
        do_write(8'h35, 8'h12, 8, 1'b1, 3'd0, 1'b0);
        read_check("R6");  // also R2 address alignment, R5 layout
    endtask

    task automatic t_copy();
        pulse_copy();
        read_check("R7");
    endtask

    task automatic t_partial_tail();
        for (int i = 0; i < 8; i++) wbuf[i] = 8'hC0 ^ 8'(i * 7);
        do_write(8'hFF, 8'h03, 8, 1'b0, 3'd3, 1'b0);
        read_check("R6");  // partial flag set, copy flag cleared (R7)
    endtask

    task automatic t_short_write();
        pulse_copy();
        for (int i = 0; i < 8; i++) wbuf[i] = 8'h5A + 8'(i);
        do_write(8'h48, 8'h7E, 4, 1'b0, 3'd0, 1'b0);
        read_check("R6");  // only 4 slots new, partial flag stays set
    endtask

    task automatic t_unknown();
        send_byte(8'h55);
        send_byte(8'h0F);
        send_byte(8'hAA);
        @(negedge clk);
        n_cmp++;
        if (!(in_ready && !out_valid)) begin
            n_bad++;
            $display("FAIL R8 unknown command: actual ready=%0b valid=%0b expected 1/0", in_ready, out_valid);
        end
        end_txn(3'd5);
        read_check("R8");
    endtask

    task automatic t_abort_read();
        logic [7:0] got;
        send_byte(8'hAA);
        recv_byte(got);
        recv_byte(got);
        recv_byte(got);
        end_txn(3'd6);  // residual bits during a read leave flags alone
        read_check("R9");
    endtask

    task automatic t_copy_vs_write();
        pulse_copy();
        for (int i = 0; i < 8; i++) wbuf[i] = 8'hE1 - 8'(i * 3);
        do_write(8'h07, 8'hA0, 8, 1'b1, 3'd0, 1'b1);
        read_check("R7");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_full_write();
        t_copy();
        t_partial_tail();
        t_short_write();
        t_unknown();
        t_abort_read();
        t_copy_vs_write();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule